// File: doc/BRIEF.md
# SPI Memory Status Register Controller

This block is the status-register slice of an SPI-slave serial memory. It oversamples chip select, serial clock, serial data in and the write-protect pin with the system clock. It decodes three single-byte instructions: write enable, read status and write status. It keeps the write-enable latch and drives serial data out while a status read is under way.

A status write that is accepted does not change the register straight away. It starts a self-timed cycle of a parameterised number of system clocks. During that cycle the write-in-progress flag reads 1, and the new protect settings are applied only when the cycle ends.

The two block-protect bits are exported so that array-side logic can map them to read-only address ranges. The status-write-disable bit, combined with a low write-protect pin, locks the register against writes.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, `prot_bp` is 0 and `miso` is 0.
- R2: A frame of exactly eight bits carrying opcode 0x06 sets the write-enable latch, which is status bit 1, when chip select rises.
- R3: Opcode 0x05 returns the status byte {disable, 0, 0, 0, BP1, BP0, latch, busy}, MSB first. Data in is sampled on the rising SCK edge and data out changes on the falling SCK edge. The byte repeats for as long as chip select stays low.
- R4: A write-status frame (opcode 0x01 followed by one data byte) is ignored unless the write-enable latch is 1.
- R5: A write-status frame takes effect only if chip select rises after exactly sixteen SCK rising edges. A frame that ends one bit early or one bit late is discarded.
- R6: Data bits 6, 5, 4, 1 and 0 of a status write are ignored. Status bits 6 to 4 always read 0.
- R7: An accepted status write holds the busy bit (status bit 0) at 1 for WRITE_CYCLES system clocks, and the status can be read during that time. At the end of the cycle both the busy bit and the write-enable latch clear.
- R8: The disable bit (status bit 7) and BP1/BP0 (status bits 3/2, also on `prot_bp`) take their new values only at the end of the self-timed cycle.
- R9: While the disable bit is 1 and `wp_n` is low, a write-status frame is not executed and the latch keeps its value.
- R10: Write-enable and write-status frames that arrive while a cycle is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and for timing the write cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out during status reads, 0 otherwise |
| prot_bp | output | 2 | Committed block-protect bits {BP1, BP0} |

## Verification
The bench sends frames that end one bit short and one bit long of the sixteen-bit write. A design that ignored the chip-select window would commit those frames and show new protect bits on readback. It issues write enable and write status in the middle of a running cycle: a design that honoured them would keep the latch set after the cycle or commit the second value. It writes 0xFF to prove that reserved bits and the latch and busy bits cannot be forced. It compares `prot_bp` on every clock against a model that moves the bits only on the exact cycle the timed write ends, which catches an early commit or a wrong cycle length. It also tries a write with the disable bit set and the pin low: a design missing the hardware lock would clear the disable bit.

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int unsigned WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       wp_n,
  output logic       miso,
  output logic [1:0] prot_bp
);
  localparam int unsigned TW = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q, wp_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= 3'b111;
      mosi_q <= '0;
      wp_q   <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
      wp_q   <= {wp_q[0], wp_n};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire sel      = ~cs_q[1];
  wire cs_rise  = cs_q[1] & ~cs_q[2];

  logic [6:0] shreg;
  logic [2:0] bit_cnt, rd_bit;
  logic [1:0] byte_cnt;
  logic [7:0] opcode, snap;
  logic       rd_on, miso_r;
  logic       nx_srwd, pend_srwd;
  logic [1:0] nx_bp, pend_bp;

  logic       srwd, wel, wip;
  logic [1:0] bp_r;
  logic [TW-1:0] timer;

  wire [7:0] rx_byte = {shreg, mosi_q[1]};
  wire [7:0] status  = {srwd, 3'b000, bp_r, wel, wip};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      rd_on    <= 1'b0;
      nx_srwd  <= 1'b0;
      nx_bp    <= '0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      rd_on    <= 1'b0;
    end else if (sck_rise) begin
      shreg   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
        if (byte_cnt == 2'd0) begin
          opcode <= rx_byte;
          rd_on  <= (rx_byte == OP_RDSR);
        end
        if (byte_cnt == 2'd1) begin
          nx_srwd <= rx_byte[7];
          nx_bp   <= rx_byte[3:2];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      miso_r <= 1'b0;
      rd_bit <= '0;
      snap   <= '0;
    end else if (!sel) begin
      miso_r <= 1'b0;
      rd_bit <= '0;
    end else if (sck_fall && rd_on) begin
      rd_bit <= rd_bit + 3'd1;
      if (rd_bit == 3'd0) begin
        snap   <= status;
        miso_r <= status[7];
      end else begin
        miso_r <= snap[~rd_bit];
      end
    end

  wire frame_wren = cs_rise && opcode == OP_WREN && byte_cnt == 2'd1 && bit_cnt == 3'd0;
  wire frame_wrsr = cs_rise && opcode == OP_WRSR && byte_cnt == 2'd2 && bit_cnt == 3'd0;
  wire locked     = srwd & ~wp_q[1];
  wire start      = frame_wrsr & wel & ~wip & ~locked;
  wire done       = wip && timer == TW'(WRITE_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      srwd      <= 1'b0;
      bp_r      <= '0;
      wel       <= 1'b0;
      wip       <= 1'b0;
      timer     <= '0;
      pend_srwd <= 1'b0;
      pend_bp   <= '0;
    end else begin
      if (start) begin
        wip       <= 1'b1;
        timer     <= '0;
        pend_srwd <= nx_srwd;
        pend_bp   <= nx_bp;
      end else if (done) begin
        wip  <= 1'b0;
        wel  <= 1'b0;
        srwd <= pend_srwd;
        bp_r <= pend_bp;
      end else if (wip) begin
        timer <= timer + 1'b1;
      end
      if (frame_wren && !wip) wel <= 1'b1;
    end

  assign miso    = miso_r;
  assign prot_bp = bp_r;
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk #(
  parameter int unsigned WRITE_CYCLES = 250000,
  parameter int unsigned TW = $clog2(WRITE_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_n,
  input logic          wip,
  input logic          wel,
  input logic          srwd,
  input logic [1:0]    bp,
  input logic [TW-1:0] timer
);
  p_end_clears_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> int'(timer) < int'(WRITE_CYCLES));
  p_bp_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(wip) |-> ($stable(bp) && $stable(srwd)));
  p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  p_hw_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !($past(srwd) && !$past(wp_n)));
  p_wren_idle_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(wip));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wip(wip), .wel(wel),
  .srwd(srwd), .bp(bp_r), .timer(timer)
);

// File: tb/tb_spi_status_ctrl.sv
module tb_spi_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T = 400;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  logic [1:0] prot_bp;

  spi_status_ctrl #(.WRITE_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .prot_bp(prot_bp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural model
  longint cyc = 0, commit_cyc = 0;
  logic m_srwd = 0, m_wel = 0, p_srwd = 0;
  logic [1:0] m_bp = 0, p_bp = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == commit_cyc) begin
      m_srwd = p_srwd; m_bp = p_bp; m_wel = 0;
    end
  end

  function automatic logic busy();
    return cyc < commit_cyc;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_srwd, 3'b000, m_bp, m_wel, busy()};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !finished) check("R8 prot_bp", prot_bp, m_bp);

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      half();
      rx[7-i] = miso;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic end_frame();
    half();
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic wren(input int nbits);
    logic [7:0] rx;
    cs_n = 1'b0; half();
    xfer(8'h06, nbits, rx);
    if (nbits == 8 && !busy()) m_wel = 1;
    end_frame();
  endtask

  task automatic wrsr(input logic [7:0] d, input int dbits);
    logic [7:0] rx;
    cs_n = 1'b0; half();
    xfer(8'h01, 8, rx);
    xfer(d, dbits, rx);
    if (dbits == 8 && dbits == 8 && m_wel && !busy() && !(m_srwd && !wp_n)) begin
      p_srwd = d[7]; p_bp = d[3:2];
      half();
      cs_n = 1'b1;
      commit_cyc = cyc + T + 3;
      half(); half();
    end else if (dbits == 9) begin
      end_frame();
    end else begin
      end_frame();
    end
  endtask

  task automatic rdsr(input string req, input int nbytes);
    logic [7:0] rx;
    cs_n = 1'b0; half();
    xfer(8'h05, 8, rx);
    for (int k = 0; k < nbytes; k++) begin
      xfer(8'h00, 8, rx);
      check(req, rx, m_status());
    end
    end_frame();
    check("R3 miso idle", miso, 0);
  endtask

  task automatic settle();
    repeat (T + 40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 prot_bp", prot_bp, 0);
    check("R1 miso", miso, 0);
    rdsr("R1 status", 1);
    // R4: write without latch ignored
    wrsr(8'h8C, 8); settle();
    rdsr("R4 no latch", 1);
    // R2: latch set -> 0x02
    wren(8);
    rdsr("R2 latch", 1);
    // R5: one bit short, one bit long
    wrsr(8'hFF, 7); settle();
    rdsr("R5 short frame", 1);
    wrsr(8'hFF, 9); settle();
    rdsr("R5 long frame", 1);
    // R6/R7/R8: write 0xFF, busy read shows 0x03
    wrsr(8'hFF, 8);
    rdsr("R7 busy read", 1);
    // R10: requests during cycle are ignored
    wren(8);
    wrsr(8'h00, 8);
    check("R8 bp held", prot_bp, 0);
    settle();
    // R3 two repeated bytes; expect 0x8C
    rdsr("R6 R7 committed", 2);
    check("R10 latch cleared", m_status(), 8'h8C);
    // R9: lock with pin low
    wp_n = 1'b0;
    wren(8);
    rdsr("R9 latch set", 1);
    wrsr(8'h00, 8); settle();
    rdsr("R9 locked", 1);
    check("R9 bp kept", prot_bp, 2'b11);
    // pin high releases lock
    wp_n = 1'b1;
    repeat (8) @(negedge clk);
    wrsr(8'h04, 8); settle();
    rdsr("R8 unlocked write", 3);
    check("R8 bp new", prot_bp, 2'b01);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule